// File: doc/BRIEF.md
# Paged memory protection checker

This block sits in front of a core-local memory and decides, for every access, whether the access may proceed. The protected window is a power-of-two region divided into equal pages. Every page has its own attribute entry. The entry holds separate read, write and execute rights for user mode and for supervisor mode. It also holds two origin gates: one admits direct core accesses and one admits DMA and other system masters. The grant decision is combinational from the request inputs. A denied access produces a one-cycle fault pulse on the next clock edge and loads an error record, which software later clears.

Before the page lookup, the block turns an aliased short-form address into the owning core's global address. Only a direct core access may use the short form. DMA traffic is always global, even when the local core programmed it. A global request whose top byte is zero therefore does not point into this window, and it passes unchecked, as does any other address outside the window. Attribute entries are loaded through a plain page-index/data/write-enable port.

The error record is kept by a three-state machine. ST_CLEAR means no record is held. The transition "capture" moves it to ST_HELD on a denied access. The transition "overrun" moves ST_HELD to ST_OVER on a further denial while the record is held. The transition "release" moves ST_HELD or ST_OVER back to ST_CLEAR on a software clear. The transition "recapture" moves either held state to ST_HELD when a clear and a denial arrive together.

Top module: `page_guard`

## Requirements
- R1: After reset every attribute entry is 8'hFF (all rights, both origin gates open), no error record is held and the fault output is low.
- R2: An attribute entry is 8 bits: bit0 user read, bit1 user write, bit2 user execute, bit3 supervisor read, bit4 supervisor write, bit5 supervisor execute. Access type codes are 0 read, 1 write, 2 execute. For an in-window access, the right selected by the mode (req_sup=1 supervisor) and the type must be set for a grant. Type code 3 is always denied inside the window.
- R3: Attribute bit6 admits direct core accesses (req_local=1) and bit7 admits global accesses (req_local=0). A grant inside the window needs the gate for the request's origin. With both bits clear, every in-window access is denied.
- R4: A direct core access whose top 8 address bits are zero has those bits replaced by the core prefix (default 8'h10) before the lookup. The page index is taken from the normalised address bits just above the page offset (default bits 18:14 in a window at 0x10800000 of 32 pages of 16 KB).
- R5: An access whose normalised address lies outside the window is granted regardless of attributes. This includes a global request presented in the short form.
- R6: An attribute write to a page takes effect on the cycle after it is presented. A request in the same cycle still sees the old entry.
- R7: fault is high in the cycle after each cycle in which req_valid is high and grant is low, and low after any other cycle.
- R8: When no record is held, a denied access loads err_addr (the normalised address), err_type, err_sup and err_id. The record does not change while it is held.
- R9: A denied access while a record is held sets err_ovf. err_ovf stays set, and the first record is kept, until a clear.
- R10: err_clr drops err_valid and err_ovf on the next edge. If a denied access arrives in the same cycle as the clear, that access is recorded instead, with err_ovf low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Access address, short or global form |
| req_type | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| req_sup | input | 1 | 1 supervisor mode, 0 user mode |
| req_local | input | 1 | 1 direct core access, 0 DMA or system master |
| req_id | input | ID_W | Requestor privilege ID |
| cfg_we | input | 1 | Attribute write enable |
| cfg_page | input | PAGE_W | Page index of the attribute write |
| cfg_data | input | 8 | New attribute entry |
| err_clr | input | 1 | Clear the error record |
| grant | output | 1 | Combinational access decision |
| fault | output | 1 | One-cycle fault event |
| err_valid | output | 1 | Error record held |
| err_ovf | output | 1 | Further fault while record held |
| err_addr | output | ADDR_W | Recorded normalised address |
| err_type | output | 2 | Recorded access type |
| err_sup | output | 1 | Recorded privilege mode |
| err_id | output | ID_W | Recorded requestor ID |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a software clear and a fresh denial. The bench raises err_clr in the same cycle as a denied request, once from ST_HELD and once from ST_OVER. It expects the new address in the record and err_ovf low. The second pair is an attribute write and a request to the same page: the write closes a page while an access to it is in flight. The bench expects a grant in that cycle and a denial with a fault on the repeat access one cycle later.

// File: rtl/pg_pkg.sv
package pg_pkg;

    localparam int ATTR_W = 8;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Page attribute entry; bit positions are visible at the config port.
    typedef struct packed {
        logic orig_glb;   // bit7: global origin gate
        logic orig_loc;   // bit6: direct core origin gate
        logic s_x;        // bit5
        logic s_w;        // bit4
        logic s_r;        // bit3
        logic u_x;        // bit2
        logic u_w;        // bit1
        logic u_r;        // bit0
    } attr_t;

    localparam attr_t ATTR_OPEN = attr_t'(8'hFF);

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_HELD  = 2'd1,
        ST_OVER  = 2'd2
    } err_state_e;

endpackage

// File: rtl/pg_addr_norm.sv
module pg_addr_norm #(
    parameter int ADDR_W = 32,
    parameter int ALIAS_W = 8,
    parameter bit ALIAS_EN = 1'b1,
    parameter logic [ALIAS_W-1:0] CORE_PREFIX = 8'h10,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h1080_0000,
    parameter int NUM_PAGES = 32,
    parameter int PAGE_LOG2 = 14,
    localparam int PAGE_W = $clog2(NUM_PAGES),
    localparam int RGN_LOG2 = PAGE_LOG2 + PAGE_W
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_local,
    output logic [ADDR_W-1:0] norm_addr,
    output logic              in_range,
    output logic [PAGE_W-1:0] page_idx
);

    generate
        if (ALIAS_EN) begin : g_alias
            logic short_form;
            assign short_form = req_local && (req_addr[ADDR_W-1 -: ALIAS_W] == '0);
            assign norm_addr  = short_form ? {CORE_PREFIX, req_addr[ADDR_W-ALIAS_W-1:0]}
                                           : req_addr;
        end else begin : g_no_alias
            logic unused_local;
            assign unused_local = req_local;
            assign norm_addr    = req_addr;
        end
    endgenerate

    assign in_range = (norm_addr[ADDR_W-1:RGN_LOG2] == REGION_BASE[ADDR_W-1:RGN_LOG2]);
    assign page_idx = norm_addr[RGN_LOG2-1:PAGE_LOG2];

endmodule

// File: rtl/pg_attr_table.sv
module pg_attr_table
    import pg_pkg::*;
#(
    parameter int NUM_PAGES = 32,
    localparam int PAGE_W = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    input  attr_t             wr_attr,
    input  logic [PAGE_W-1:0] rd_page,
    output attr_t             rd_attr
);

    attr_t entries [NUM_PAGES];

    generate
        for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
            attr_t entry_q;
            logic  hit;
            assign hit = wr_en && (wr_page == PAGE_W'(g));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    entry_q <= ATTR_OPEN;
                end else if (hit) begin
                    entry_q <= wr_attr;
                end
            end
            assign entries[g] = entry_q;
        end
    endgenerate

    assign rd_attr = entries[rd_page];

endmodule

// File: rtl/pg_err_fsm.sv
module pg_err_fsm
    import pg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deny,
    input  logic              clr,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [1:0]        cap_type,
    input  logic              cap_sup,
    input  logic [ID_W-1:0]   cap_id,
    output logic              fault,
    output logic              err_valid,
    output logic              err_ovf,
    output logic [ADDR_W-1:0] err_addr,
    output logic [1:0]        err_type,
    output logic              err_sup,
    output logic [ID_W-1:0]   err_id
);

    err_state_e state_q, state_d;
    logic       capture;
    logic       fault_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: capture, overrun, release, recapture
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (deny) state_d = ST_HELD;
            end
            ST_HELD: begin
                if (clr)       state_d = deny ? ST_HELD : ST_CLEAR;
                else if (deny) state_d = ST_OVER;
            end
            ST_OVER: begin
                if (clr) state_d = deny ? ST_HELD : ST_CLEAR;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    assign capture = deny && ((state_q == ST_CLEAR) || clr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q  <= 1'b0;
            err_addr <= '0;
            err_type <= '0;
            err_sup  <= 1'b0;
            err_id   <= '0;
        end else begin
            fault_q <= deny;
            if (capture) begin
                err_addr <= cap_addr;
                err_type <= cap_type;
                err_sup  <= cap_sup;
                err_id   <= cap_id;
            end
        end
    end

    // Outputs
    always_comb begin
        fault     = fault_q;
        err_valid = (state_q != ST_CLEAR);
        err_ovf   = (state_q == ST_OVER);
    end

endmodule

// File: rtl/page_guard.sv
module page_guard
    import pg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W = 4,
    parameter int NUM_PAGES = 32,
    parameter int PAGE_LOG2 = 14,
    parameter int ALIAS_W = 8,
    parameter bit ALIAS_EN = 1'b1,
    parameter logic [ALIAS_W-1:0] CORE_PREFIX = 8'h10,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h1080_0000,
    localparam int PAGE_W = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_type,
    input  logic              req_sup,
    input  logic              req_local,
    input  logic [ID_W-1:0]   req_id,
    input  logic              cfg_we,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic [7:0]        cfg_data,
    input  logic              err_clr,
    output logic              grant,
    output logic              fault,
    output logic              err_valid,
    output logic              err_ovf,
    output logic [ADDR_W-1:0] err_addr,
    output logic [1:0]        err_type,
    output logic              err_sup,
    output logic [ID_W-1:0]   err_id
);

    logic [ADDR_W-1:0] norm_addr;
    logic              in_range;
    logic [PAGE_W-1:0] page_idx;
    attr_t             cur_attr;
    logic              right_ok;
    logic              origin_ok;
    logic              deny;

    pg_addr_norm #(
        .ADDR_W     (ADDR_W),
        .ALIAS_W    (ALIAS_W),
        .ALIAS_EN   (ALIAS_EN),
        .CORE_PREFIX(CORE_PREFIX),
        .REGION_BASE(REGION_BASE),
        .NUM_PAGES  (NUM_PAGES),
        .PAGE_LOG2  (PAGE_LOG2)
    ) norm_i (
        .req_addr (req_addr),
        .req_local(req_local),
        .norm_addr(norm_addr),
        .in_range (in_range),
        .page_idx (page_idx)
    );

    pg_attr_table #(
        .NUM_PAGES(NUM_PAGES)
    ) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_page(cfg_page),
        .wr_attr(attr_t'(cfg_data)),
        .rd_page(page_idx),
        .rd_attr(cur_attr)
    );

    // Right selection by mode and access type
    always_comb begin
        unique case (acc_e'(req_type))
            ACC_READ:  right_ok = req_sup ? cur_attr.s_r : cur_attr.u_r;
            ACC_WRITE: right_ok = req_sup ? cur_attr.s_w : cur_attr.u_w;
            ACC_EXEC:  right_ok = req_sup ? cur_attr.s_x : cur_attr.u_x;
            default:   right_ok = 1'b0;
        endcase
    end

    assign origin_ok = req_local ? cur_attr.orig_loc : cur_attr.orig_glb;
    assign grant     = !in_range || (right_ok && origin_ok);
    assign deny      = req_valid && !grant;

    pg_err_fsm #(
        .ADDR_W(ADDR_W),
        .ID_W  (ID_W)
    ) err_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .deny     (deny),
        .clr      (err_clr),
        .cap_addr (norm_addr),
        .cap_type (req_type),
        .cap_sup  (req_sup),
        .cap_id   (req_id),
        .fault    (fault),
        .err_valid(err_valid),
        .err_ovf  (err_ovf),
        .err_addr (err_addr),
        .err_type (err_type),
        .err_sup  (err_sup),
        .err_id   (err_id)
    );

endmodule

// File: rtl/page_guard_chk.sv
module page_guard_chk #(
    parameter int ADDR_W = 32,
    parameter int NUM_PAGES = 32,
    parameter int PAGE_LOG2 = 14,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h1080_0000,
    localparam int RGN_LOG2 = PAGE_LOG2 + $clog2(NUM_PAGES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_local,
    input logic              grant,
    input logic              fault,
    input logic              err_clr,
    input logic              err_valid,
    input logic              err_ovf,
    input logic [ADDR_W-1:0] err_addr
);

    assert_fault_after_deny_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !grant) |=> fault);

    assert_quiet_after_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !grant) |=> !fault);

    assert_outside_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_local && (req_addr[ADDR_W-1:RGN_LOG2] != REGION_BASE[ADDR_W-1:RGN_LOG2]))
        |-> grant);

    assert_record_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !err_clr) |=> (err_valid && $stable(err_addr)));

    assert_ovf_needs_record_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |-> err_valid);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovf && !err_clr) |=> err_ovf);

    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(req_valid && !grant)) |=> (!err_valid && !err_ovf));

    assert_clear_recapture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && req_valid && !grant) |=> (err_valid && !err_ovf));

endmodule

bind page_guard page_guard_chk #(
    .ADDR_W     (ADDR_W),
    .NUM_PAGES  (NUM_PAGES),
    .PAGE_LOG2  (PAGE_LOG2),
    .REGION_BASE(REGION_BASE)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_local(req_local),
    .grant    (grant),
    .fault    (fault),
    .err_clr  (err_clr),
    .err_valid(err_valid),
    .err_ovf  (err_ovf),
    .err_addr (err_addr)
);

// File: tb/page_guard_tb_top.sv
`timescale 1ns/1ps
module page_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_type = '0;
    logic        req_sup = 1'b0;
    logic        req_local = 1'b0;
    logic [3:0]  req_id = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_page = '0;
    logic [7:0]  cfg_data = '0;
    logic        err_clr = 1'b0;
    logic        grant, fault, err_valid, err_ovf, err_sup;
    logic [31:0] err_addr;
    logic [1:0]  err_type;
    logic [3:0]  err_id;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    page_guard dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_type(req_type), .req_sup(req_sup), .req_local(req_local), .req_id(req_id),
        .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_data(cfg_data), .err_clr(err_clr),
        .grant(grant), .fault(fault), .err_valid(err_valid), .err_ovf(err_ovf),
        .err_addr(err_addr), .err_type(err_type), .err_sup(err_sup), .err_id(err_id)
    );

    // Reference state built from the requirements
    logic [7:0]  bm_attr [32];
    logic        bm_valid = 1'b0, bm_ovf = 1'b0, bm_sup = 1'b0;
    logic [31:0] bm_addr = '0;
    logic [1:0]  bm_type = '0;
    logic [3:0]  bm_id = '0;

    // Scoreboard: {fault, valid, ovf, addr, type, sup, id}
    logic [41:0] q_exp [$];
    string       q_tag [$];

    function automatic logic [31:0] pa(int pg, int off);
        return 32'h1080_0000 + 32'(pg) * 32'h4000 + 32'(off);
    endfunction

    task automatic step(string tag, logic v, logic [31:0] a, logic [1:0] t, logic s,
                        logic l, logic [3:0] id, logic we, logic [4:0] wp,
                        logic [7:0] wd, logic c);
        logic [31:0] n;
        logic        inr, pb, ob, eg, dn;
        logic [4:0]  p;
        int          bi;
        @(negedge clk);
        req_valid = v; req_addr = a; req_type = t; req_sup = s; req_local = l;
        req_id = id; cfg_we = we; cfg_page = wp; cfg_data = wd; err_clr = c;
        n   = (l && a[31:24] == 8'h00) ? {8'h10, a[23:0]} : a;
        inr = (n[31:19] == 13'h0210);
        p   = n[18:14];
        bi  = (s ? 3 : 0) + int'(t);
        pb  = (t == 2'd3) ? 1'b0 : bm_attr[p][bi];
        ob  = l ? bm_attr[p][6] : bm_attr[p][7];
        eg  = !inr || (pb && ob);
        #1;
        if (v) begin
            n_checks++;
            if (grant !== eg) begin
                n_fail++;
                $display("FAIL %s grant=%0b expected %0b (addr %h)", tag, grant, eg, a);
            end
        end
        dn = v && !eg;
        if (dn && (!bm_valid || c)) begin
            bm_valid = 1'b1; bm_ovf = 1'b0;
            bm_addr = n; bm_type = t; bm_sup = s; bm_id = id;
        end else if (c) begin
            bm_valid = 1'b0; bm_ovf = 1'b0;
        end else if (dn) begin
            bm_ovf = 1'b1;
        end
        if (we) bm_attr[wp] = wd;
        q_exp.push_back({dn, bm_valid, bm_ovf, bm_addr, bm_type, bm_sup, bm_id});
        q_tag.push_back(tag);
    endtask

    task automatic acc(string tag, logic [31:0] a, logic [1:0] t, logic s, logic l,
                       logic [3:0] id);
        step(tag, 1'b1, a, t, s, l, id, 1'b0, 5'd0, 8'h00, 1'b0);
    endtask

    task automatic wr(string tag, logic [4:0] p, logic [7:0] d);
        step(tag, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 4'd0, 1'b1, p, d, 1'b0);
    endtask

    task automatic clr(string tag);
        step(tag, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 4'd0, 1'b0, 5'd0, 8'h00, 1'b1);
    endtask

    task automatic idle(string tag);
        step(tag, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 4'd0, 1'b0, 5'd0, 8'h00, 1'b0);
    endtask

    // Monitor: compare registered outputs after each edge
    initial begin
        logic [41:0] e;
        string       tg;
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() > 0) begin
                e  = q_exp.pop_front();
                tg = q_tag.pop_front();
                n_checks++;
                if (fault !== e[41] || err_valid !== e[40] || err_ovf !== e[39]) begin
                    n_fail++;
                    $display("FAIL %s fault/valid/ovf=%0b%0b%0b expected %0b%0b%0b",
                             tg, fault, err_valid, err_ovf, e[41], e[40], e[39]);
                end
                if (e[40] && (err_addr !== e[38:7] || err_type !== e[6:5] ||
                              err_sup !== e[4] || err_id !== e[3:0])) begin
                    n_fail++;
                    $display("FAIL %s record addr=%h type=%0d sup=%0b id=%0d expected %h %0d %0b %0d",
                             tg, err_addr, err_type, err_sup, err_id,
                             e[38:7], e[6:5], e[4], e[3:0]);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) bm_attr[i] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        idle("R1 reset state");
        acc("R1 open page 0", pa(0, 0), 2'd2, 1'b1, 1'b1, 4'd1);
        acc("R1 open page 31", pa(31, 8), 2'd1, 1'b0, 1'b0, 4'd3);

        wr("R2 cfg", 5'd3, 8'hC1);
        acc("R2 user read ok", pa(3, 16), 2'd0, 1'b0, 1'b1, 4'd2);
        acc("R2 user write denied", pa(3, 16), 2'd1, 1'b0, 1'b1, 4'd2);
        acc("R9 overrun keeps first record", pa(3, 32), 2'd0, 1'b1, 1'b1, 4'd5);
        idle("R9 ovf sticky");
        clr("R10 clear alone");
        acc("R2 reserved type denied", pa(4, 0), 2'd3, 1'b1, 1'b1, 4'd6);
        clr("R10 clear");

        wr("R3 cfg local only", 5'd5, 8'h7F);
        acc("R3 local ok", pa(5, 0), 2'd0, 1'b0, 1'b1, 4'd1);
        acc("R3 global denied", pa(5, 0), 2'd0, 1'b0, 1'b0, 4'd7);
        clr("R10 clear");
        wr("R3 cfg global only", 5'd5, 8'hBF);
        acc("R3 global ok", pa(5, 4), 2'd1, 1'b1, 1'b0, 4'd7);
        acc("R3 local denied", pa(5, 4), 2'd1, 1'b1, 1'b1, 4'd1);
        clr("R10 clear");
        wr("R3 cfg no origin", 5'd5, 8'h3F);
        acc("R3 none local", pa(5, 0), 2'd0, 1'b1, 1'b1, 4'd1);
        acc("R3 none global", pa(5, 0), 2'd0, 1'b1, 1'b0, 4'd7);
        clr("R10 clear");

        wr("R4 cfg", 5'd6, 8'h7F);
        acc("R4 short form ok", 32'h0081_8020, 2'd0, 1'b1, 1'b1, 4'd1);
        wr("R4 cfg closed", 5'd6, 8'h40);
        acc("R4 short form denied, record normalised", 32'h0081_8020, 2'd0, 1'b1, 1'b1, 4'd9);
        clr("R10 clear");

        acc("R5 global short form bypass", 32'h0081_8020, 2'd0, 1'b1, 1'b0, 4'd4);
        acc("R5 far address", 32'h2000_0000, 2'd1, 1'b0, 1'b0, 4'd4);
        acc("R5 just above window", 32'h1088_0000, 2'd3, 1'b0, 1'b1, 4'd4);

        step("R6 write and access same cycle", 1'b1, pa(7, 0), 2'd0, 1'b0, 1'b1, 4'd2,
             1'b1, 5'd7, 8'h00, 1'b0);
        acc("R6 new entry in force", pa(7, 0), 2'd0, 1'b0, 1'b1, 4'd2);
        acc("R7 back-to-back deny", pa(7, 64), 2'd2, 1'b1, 1'b1, 4'd3);
        acc("R7 grant after deny", pa(8, 0), 2'd2, 1'b1, 1'b1, 4'd3);
        idle("R9 ovf held");

        step("R10 clear with deny from overrun", 1'b1, pa(7, 128), 2'd1, 1'b1, 1'b0, 4'd11,
             1'b0, 5'd0, 8'h00, 1'b1);
        step("R10 clear with deny from held", 1'b1, pa(6, 256), 2'd2, 1'b0, 1'b0, 4'd12,
             1'b0, 5'd0, 8'h00, 1'b1);
        clr("R10 final clear");
        idle("R10 stays clear");
        idle("R1 idle");

        @(posedge clk);
        #3;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule